// File: doc/BRIEF.md
# Pattern Block Sequencer

The block plays stored pattern blocks out of an external pattern RAM in an order set by a programmable line table. Each table line names a block (through a descriptor holding its start address and length) or calls a sub-sequence of lines. It also carries a repeat count, which may be infinite, an optional wait-for event, an optional drive of one of four cross-module signals, and a jump rule (none, conditional on an event, or unconditional) with a target line. The table, the block descriptors and four event definitions are loaded through one write port before a run.

Events are built from eight external event inputs and one selectable cross-module input. Each event is the AND or the OR of its selected terms, and is either level-sensitive or fires on a false-to-true change. A pulse on `start_i` runs the table from line 0. The pattern RAM is read one word per cycle with one cycle of latency, and the word is passed to the output together with a valid strobe. A step mode replaces every wait and conditional-jump event with a host acknowledge pulse, so the program flow can be walked by hand. The run ends with a done flag at a line marked as the end. A configuration fault stops the run with an error flag.

Top module: `pat_seq`

## Requirements
- R1: While `rst_ni` is low and after its release, `vec_vld_o`, `pat_rd_o`, `done_o` and `err_o` are 0 and `ims_o` is 0000.
- R2: When `wr_en_i` is high, a table word is written at the rising edge. `wr_sel_i` = 0 writes line `wr_addr_i`, 1 writes block descriptor `wr_addr_i`, and 2 writes event definition `wr_addr_i`. A block word holds the length in bits [10:0] and the start address in bits [20:11]. An event word holds the required values in [7:0], the term mask in [15:8], the cross-module input index in [17:16], a use-that-input bit at 18, OR (1) or AND (0) at 19, and edge mode at 20. An AND event with no terms is always true.
- R3: A line word (default widths) holds the target line in [5:0], the block index in [9:6], the repeat field in [25:10], infinite at 26, the jump event in [28:27], the jump mode in [30:29] (0 none, 1 conditional, 2 always), the wait event in [32:31], wait enable at 33, signal value at 34, signal index in [36:35], signal enable at 37, call at 38, return at 39 and end at 40.
- R4: A block line emits the pattern words at addresses start through start+length-1 in ascending order on `vec_o`, each qualified by `vec_vld_o`.
- R5: A repeat field of n plays the block n+1 times back to back. With infinite set, the block is replayed without end and the line is never left.
- R6: With wait enabled, no word of the line is emitted until the selected event is true. The event is true when its selected external bits equal their required values (AND), or when any of them does (OR), combined in the same way with the chosen cross-module input when that input is enabled.
- R7: An edge-mode event is true only in the cycle after its level goes from false to true. A level that is already high while the line waits does not release it.
- R8: After the last repetition, an unconditional jump always moves to the target line. A conditional jump moves there when its event holds (or, in edge mode, has fired since the block started). Otherwise execution falls through to the next line.
- R9: When the wait of a line with signal enable is satisfied, `ims_o[index]` takes the signal value, and it keeps that value until another line changes it.
- R10: A call line runs the lines from its target up to and including a return line, repeat field + 1 times, and then continues at the line after the call (or finishes if the call line has end set). The vectors produced match those of the same lines written inline.
- R11: A call met inside a sub-sequence, or a sub-sequence line SUB_MAX or more lines past its first line, stops the run with `err_o` high and no further vectors. The error state is held until the next start.
- R12: A block shorter than MIN_FULL words (`half_i` = 0) or MIN_HALF words (`half_i` = 1) emits nothing and stops the run with `err_o` high.
- R13: With `step_i` high, a wait and a conditional jump are satisfied only by an `ack_i` pulse. For the jump, a pulse during the block's output or at the decision counts, and the event inputs are ignored.
- R14: A line with end set whose jump is not taken raises `done_o`, which holds until `start_i`. `start_i` restarts from line 0, and `done_o` and `err_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table write strobe |
| wr_sel_i | input | 2 | Table select: line, block, event |
| wr_addr_i | input | 6 | Entry index |
| wr_data_i | input | 41 | Entry word |
| start_i | input | 1 | Run from line 0 |
| step_i | input | 1 | Manual step mode |
| ack_i | input | 1 | Host acknowledge in step mode |
| half_i | input | 1 | Half-channel mode (raises minimum block length) |
| ext_ev_i | input | 8 | External event inputs |
| ims_i | input | 4 | Cross-module signals in |
| pat_addr_o | output | 10 | Pattern RAM address |
| pat_rd_o | output | 1 | Pattern RAM read |
| pat_data_i | input | 16 | Pattern RAM data, one cycle after the read |
| vec_o | output | 16 | Output vector |
| vec_vld_o | output | 1 | Output vector valid |
| ims_o | output | 4 | Cross-module signals out |
| done_o | output | 1 | Run finished at an end line |
| err_o | output | 1 | Run stopped on a configuration fault |

## Verification
The bench keeps the default vector width, table depth, block count, repeat width and sub-sequence limit, but lowers MIN_FULL to 4 and MIN_HALF to 8. This lets blocks of three to eight words cover every ordering case, repeated sub-sequence calls included, within a few thousand cycles. With short blocks a second acknowledge pulse can land inside a running block, and both sides of each length minimum can be reached with small descriptors. The infinite repeat setting is observed over several full passes before a reset ends it.

// File: rtl/pat_seq_pkg.sv
package pat_seq_pkg;
  localparam int EXT_N      = 8;
  localparam int IMS_N      = 4;
  localparam int IMS_IDX_W  = $clog2(IMS_N);
  localparam int EV_N       = 4;
  localparam int EV_IDX_W   = $clog2(EV_N);
  localparam int JMP_W      = 2;
  // flag bits of a line: end, ret, call, sig_en, sig_val, wait_en, rpt_inf
  localparam int LINE_FIX_W = 7 + IMS_IDX_W + 2 * EV_IDX_W + JMP_W;

  typedef enum logic [1:0] {
    WR_LINE = 2'd0,
    WR_BLK  = 2'd1,
    WR_EVT  = 2'd2
  } wr_sel_e;

  typedef enum logic [JMP_W-1:0] {
    JMP_NONE   = 2'd0,
    JMP_COND   = 2'd1,
    JMP_ALWAYS = 2'd2
  } jmp_mode_e;

  typedef struct packed {
    logic                 edge_mode;
    logic                 op_or;
    logic                 sig_use;
    logic [IMS_IDX_W-1:0] sig_sel;
    logic [EXT_N-1:0]     mask;
    logic [EXT_N-1:0]     val;
  } ev_def_t;
endpackage

// File: rtl/pat_seq_evt.sv
module pat_seq_evt
  import pat_seq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [EXT_N-1:0]    ext_ev_i,
  input  logic [IMS_N-1:0]    ims_i,
  input  ev_def_t             def_i [EV_N],
  output logic [EV_N-1:0]     hit_o
);
  logic [EV_N-1:0] lvl, prev_q;

  for (genvar e = 0; e < EV_N; e++) begin : g_ev
    logic [EXT_N-1:0] match;
    logic             sig_bit;
    assign match   = ~(ext_ev_i ^ def_i[e].val) & def_i[e].mask;
    assign sig_bit = ims_i[def_i[e].sig_sel];
    always_comb begin
      if (def_i[e].op_or)
        lvl[e] = (|match) | (def_i[e].sig_use & sig_bit);
      else
        lvl[e] = (&(match | ~def_i[e].mask)) & (~def_i[e].sig_use | sig_bit);
    end
    assign hit_o[e] = def_i[e].edge_mode ? (lvl[e] & ~prev_q[e]) : lvl[e];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl;
  end
endmodule

// File: rtl/pat_seq_tbl.sv
module pat_seq_tbl
  import pat_seq_pkg::*;
#(
  parameter int LINES   = 64,
  parameter int BLOCKS  = 16,
  parameter int PADDR_W = 10,
  parameter int LW      = 41,
  parameter int AW      = 6,
  parameter int WD_W    = 41,
  localparam int LINE_W = $clog2(LINES),
  localparam int BLK_W  = $clog2(BLOCKS),
  localparam int LEN_W  = PADDR_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [WD_W-1:0]    wr_data_i,
  input  logic [LINE_W-1:0]  line_addr_i,
  output logic [LW-1:0]      line_o,
  input  logic [BLK_W-1:0]   blk_idx_i,
  output logic [PADDR_W-1:0] blk_start_o,
  output logic [LEN_W-1:0]   blk_len_o,
  output ev_def_t            ev_o [EV_N]
);
  logic [LW-1:0]              line_mem [LINES];
  logic [PADDR_W+LEN_W-1:0]   blk_mem  [BLOCKS];
  ev_def_t                    ev_q     [EV_N];

  always_ff @(posedge clk_i) begin
    if (wr_en_i && wr_sel_i == WR_LINE)
      line_mem[wr_addr_i[LINE_W-1:0]] <= wr_data_i[LW-1:0];
    if (wr_en_i && wr_sel_i == WR_BLK)
      blk_mem[wr_addr_i[BLK_W-1:0]] <= wr_data_i[PADDR_W+LEN_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < EV_N; e++) ev_q[e] <= '0;
    end else if (wr_en_i && wr_sel_i == WR_EVT) begin
      ev_q[wr_addr_i[EV_IDX_W-1:0]] <= ev_def_t'(wr_data_i[$bits(ev_def_t)-1:0]);
    end
  end

  assign line_o      = line_mem[line_addr_i];
  assign blk_start_o = blk_mem[blk_idx_i][PADDR_W+LEN_W-1:LEN_W];
  assign blk_len_o   = blk_mem[blk_idx_i][LEN_W-1:0];
  assign ev_o        = ev_q;
endmodule

// File: rtl/pat_seq_ctrl.sv
module pat_seq_ctrl
  import pat_seq_pkg::*;
#(
  parameter int LINES    = 64,
  parameter int BLOCKS   = 16,
  parameter int PADDR_W  = 10,
  parameter int RPT_W    = 16,
  parameter int MIN_FULL = 40,
  parameter int MIN_HALF = 80,
  parameter int SUB_MAX  = 50,
  parameter int LW       = 41,
  localparam int LINE_W  = $clog2(LINES),
  localparam int BLK_W   = $clog2(BLOCKS),
  localparam int LEN_W   = PADDR_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               step_i,
  input  logic               ack_i,
  input  logic               half_i,
  input  logic [LW-1:0]      line_i,
  output logic [LINE_W-1:0]  line_addr_o,
  output logic [BLK_W-1:0]   blk_idx_o,
  input  logic [PADDR_W-1:0] blk_start_i,
  input  logic [LEN_W-1:0]   blk_len_i,
  input  logic [EV_N-1:0]    hit_i,
  input  logic [EV_N-1:0]    edge_i,
  output logic [PADDR_W-1:0] pat_addr_o,
  output logic               pat_rd_o,
  output logic [IMS_N-1:0]   ims_o,
  output logic               done_o,
  output logic               err_o
);
  typedef struct packed {
    logic                 is_end;
    logic                 is_ret;
    logic                 is_call;
    logic                 sig_en;
    logic [IMS_IDX_W-1:0] sig_sel;
    logic                 sig_val;
    logic                 wait_en;
    logic [EV_IDX_W-1:0]  wait_ev;
    logic [JMP_W-1:0]     jmp_mode;
    logic [EV_IDX_W-1:0]  jmp_ev;
    logic                 rpt_inf;
    logic [RPT_W-1:0]     rpt;
    logic [BLK_W-1:0]     blk;
    logic [LINE_W-1:0]    tgt;
  } line_t;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_WAIT, S_RUN, S_JDEC, S_DONE, S_ERR} state_e;

  localparam logic [LEN_W-1:0]  MIN_F_L = LEN_W'(MIN_FULL);
  localparam logic [LEN_W-1:0]  MIN_H_L = LEN_W'(MIN_HALF);
  localparam logic [LINE_W:0]   SUB_L   = (LINE_W+1)'(SUB_MAX);

  state_e              state_q;
  line_t               cur_q;
  logic [LINE_W-1:0]   pc_q, ret_line_q, sub_start_q;
  logic [PADDR_W-1:0]  addr_q, base_q;
  logic [LEN_W-1:0]    len_q, left_q;
  logic [RPT_W-1:0]    rpt_q, ret_cnt_q;
  logic                seen_q, in_sub_q, ret_inf_q, ret_end_q;
  logic [IMS_N-1:0]    ims_q;

  logic wait_ok, jcond_now, jsticky, jtaken, short_blk, sub_long;

  assign wait_ok   = !cur_q.wait_en || (step_i ? ack_i : hit_i[cur_q.wait_ev]);
  assign jcond_now = step_i ? ack_i : hit_i[cur_q.jmp_ev];
  assign jsticky   = step_i || edge_i[cur_q.jmp_ev];
  assign jtaken    = (cur_q.jmp_mode == JMP_ALWAYS) ||
                     ((cur_q.jmp_mode == JMP_COND) && (jcond_now || (jsticky && seen_q)));
  assign short_blk = blk_len_i < (half_i ? MIN_H_L : MIN_F_L);
  assign sub_long  = {1'b0, pc_q - sub_start_q} >= SUB_L;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      cur_q       <= '0;
      pc_q        <= '0;
      ret_line_q  <= '0;
      sub_start_q <= '0;
      addr_q      <= '0;
      base_q      <= '0;
      len_q       <= '0;
      left_q      <= '0;
      rpt_q       <= '0;
      ret_cnt_q   <= '0;
      seen_q      <= 1'b0;
      in_sub_q    <= 1'b0;
      ret_inf_q   <= 1'b0;
      ret_end_q   <= 1'b0;
      ims_q       <= '0;
    end else begin
      unique case (state_q)
        S_IDLE, S_DONE, S_ERR: begin
          if (start_i) begin
            pc_q     <= '0;
            in_sub_q <= 1'b0;
            state_q  <= S_LOAD;
          end
        end
        S_LOAD: begin
          cur_q   <= line_t'(line_i);
          state_q <= (in_sub_q && sub_long) ? S_ERR : S_WAIT;
        end
        S_WAIT: begin
          if (wait_ok) begin
            seen_q <= 1'b0;
            if (cur_q.sig_en) ims_q[cur_q.sig_sel] <= cur_q.sig_val;
            if (cur_q.is_call) begin
              if (in_sub_q) begin
                state_q <= S_ERR;
              end else begin
                in_sub_q    <= 1'b1;
                ret_line_q  <= pc_q;
                ret_cnt_q   <= cur_q.rpt;
                ret_inf_q   <= cur_q.rpt_inf;
                ret_end_q   <= cur_q.is_end;
                sub_start_q <= cur_q.tgt;
                pc_q        <= cur_q.tgt;
                state_q     <= S_LOAD;
              end
            end else if (short_blk) begin
              state_q <= S_ERR;
            end else begin
              base_q  <= blk_start_i;
              addr_q  <= blk_start_i;
              len_q   <= blk_len_i;
              left_q  <= blk_len_i;
              rpt_q   <= cur_q.rpt;
              state_q <= S_RUN;
            end
          end
        end
        S_RUN: begin
          if (jcond_now) seen_q <= 1'b1;
          if (left_q == LEN_W'(1)) begin
            if (cur_q.rpt_inf || rpt_q != '0) begin
              if (!cur_q.rpt_inf) rpt_q <= rpt_q - 1'b1;
              addr_q <= base_q;
              left_q <= len_q;
            end else begin
              state_q <= S_JDEC;
            end
          end else begin
            addr_q <= addr_q + 1'b1;
            left_q <= left_q - 1'b1;
          end
        end
        S_JDEC: begin
          state_q <= S_LOAD;
          if (jtaken) begin
            pc_q <= cur_q.tgt;
          end else if (cur_q.is_end) begin
            state_q <= S_DONE;
          end else if (cur_q.is_ret && in_sub_q) begin
            if (ret_inf_q || ret_cnt_q != '0) begin
              if (!ret_inf_q) ret_cnt_q <= ret_cnt_q - 1'b1;
              pc_q <= sub_start_q;
            end else begin
              in_sub_q <= 1'b0;
              if (ret_end_q) state_q <= S_DONE;
              else           pc_q    <= ret_line_q + 1'b1;
            end
          end else begin
            pc_q <= pc_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign line_addr_o = pc_q;
  assign blk_idx_o   = cur_q.blk;
  assign pat_addr_o  = addr_q;
  assign pat_rd_o    = (state_q == S_RUN);
  assign ims_o       = ims_q;
  assign done_o      = (state_q == S_DONE);
  assign err_o       = (state_q == S_ERR);
endmodule

// File: rtl/pat_seq.sv
module pat_seq
  import pat_seq_pkg::*;
#(
  parameter int VEC_W    = 16,
  parameter int PADDR_W  = 10,
  parameter int LINES    = 64,
  parameter int BLOCKS   = 16,
  parameter int RPT_W    = 16,
  parameter int MIN_FULL = 40,
  parameter int MIN_HALF = 80,
  parameter int SUB_MAX  = 50,
  localparam int LINE_W  = $clog2(LINES),
  localparam int BLK_W   = $clog2(BLOCKS),
  localparam int LEN_W   = PADDR_W + 1,
  localparam int LW      = LINE_FIX_W + RPT_W + BLK_W + LINE_W,
  localparam int BW      = PADDR_W + LEN_W,
  localparam int EW      = $bits(ev_def_t),
  localparam int WD_W    = (LW > BW) ? ((LW > EW) ? LW : EW) : ((BW > EW) ? BW : EW),
  localparam int AW0     = (LINE_W > BLK_W) ? LINE_W : BLK_W,
  localparam int AW      = (AW0 > EV_IDX_W) ? AW0 : EV_IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [WD_W-1:0]    wr_data_i,
  input  logic               start_i,
  input  logic               step_i,
  input  logic               ack_i,
  input  logic               half_i,
  input  logic [EXT_N-1:0]   ext_ev_i,
  input  logic [IMS_N-1:0]   ims_i,
  output logic [PADDR_W-1:0] pat_addr_o,
  output logic               pat_rd_o,
  input  logic [VEC_W-1:0]   pat_data_i,
  output logic [VEC_W-1:0]   vec_o,
  output logic               vec_vld_o,
  output logic [IMS_N-1:0]   ims_o,
  output logic               done_o,
  output logic               err_o
);
  logic [LINE_W-1:0]  line_addr;
  logic [LW-1:0]      line_word;
  logic [BLK_W-1:0]   blk_idx;
  logic [PADDR_W-1:0] blk_start;
  logic [LEN_W-1:0]   blk_len;
  ev_def_t            ev_defs [EV_N];
  logic [EV_N-1:0]    ev_hit, ev_edge;
  logic               rd_q;

  for (genvar e = 0; e < EV_N; e++) begin : g_edge
    assign ev_edge[e] = ev_defs[e].edge_mode;
  end

  pat_seq_tbl #(
    .LINES(LINES), .BLOCKS(BLOCKS), .PADDR_W(PADDR_W),
    .LW(LW), .AW(AW), .WD_W(WD_W)
  ) u_tbl (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_addr_i, .wr_data_i,
    .line_addr_i(line_addr), .line_o(line_word),
    .blk_idx_i(blk_idx), .blk_start_o(blk_start), .blk_len_o(blk_len),
    .ev_o(ev_defs)
  );

  pat_seq_evt u_evt (
    .clk_i, .rst_ni, .ext_ev_i, .ims_i, .def_i(ev_defs), .hit_o(ev_hit)
  );

  pat_seq_ctrl #(
    .LINES(LINES), .BLOCKS(BLOCKS), .PADDR_W(PADDR_W), .RPT_W(RPT_W),
    .MIN_FULL(MIN_FULL), .MIN_HALF(MIN_HALF), .SUB_MAX(SUB_MAX), .LW(LW)
  ) u_ctrl (
    .clk_i, .rst_ni, .start_i, .step_i, .ack_i, .half_i,
    .line_i(line_word), .line_addr_o(line_addr),
    .blk_idx_o(blk_idx), .blk_start_i(blk_start), .blk_len_i(blk_len),
    .hit_i(ev_hit), .edge_i(ev_edge),
    .pat_addr_o, .pat_rd_o, .ims_o, .done_o, .err_o
  );

  // pattern RAM answers one cycle after the read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= 1'b0;
    else         rd_q <= pat_rd_o;
  end

  assign vec_vld_o = rd_q;
  assign vec_o     = pat_data_i;
endmodule

// File: rtl/pat_seq_chk.sv
module pat_seq_chk #(
  parameter int IMS_N = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             vec_vld_o,
  input logic [IMS_N-1:0] ims_o,
  input logic             done_o,
  input logic             err_o
);
  AST_DONE_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o)); // R14

  AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o); // R14

  AST_DONE_NO_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !vec_vld_o); // R14

  AST_ERR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !start_i |=> err_o); // R11

  AST_ERR_NO_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !vec_vld_o); // R11

  AST_SIG_STABLE_IN_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld_o && $past(vec_vld_o) |-> $stable(ims_o)); // R9
endmodule

bind pat_seq pat_seq_chk #(.IMS_N(pat_seq_pkg::IMS_N)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .vec_vld_o(vec_vld_o),
  .ims_o(ims_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/pat_seq_tb.sv
module pat_seq_tb;
  localparam int VEC_W = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [5:0]  wr_addr = '0;
  logic [40:0] wr_data = '0;
  logic        start = 1'b0, step = 1'b0, ack = 1'b0, half = 1'b0;
  logic [7:0]  ext = '0;
  logic [3:0]  ims_in = '0;
  logic [9:0]  pat_addr;
  logic        pat_rd;
  logic [15:0] pat_data = '0;
  logic [15:0] vec;
  logic        vec_vld;
  logic [3:0]  ims_out;
  logic        done, err;

  int n_run = 0, n_fail = 0;
  logic [15:0] exp_q [$];
  bit inf_mode = 1'b0;

  always #2 clk = ~clk;

  pat_seq #(.MIN_FULL(4), .MIN_HALF(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .start_i(start), .step_i(step),
    .ack_i(ack), .half_i(half), .ext_ev_i(ext), .ims_i(ims_in),
    .pat_addr_o(pat_addr), .pat_rd_o(pat_rd), .pat_data_i(pat_data),
    .vec_o(vec), .vec_vld_o(vec_vld), .ims_o(ims_out), .done_o(done), .err_o(err)
  );

  function automatic logic [15:0] patf(input logic [9:0] a);
    return 16'(({6'd0, a} * 16'h03B1) ^ 16'h5A5A);
  endfunction

  always @(posedge clk) pat_data <= patf(pat_addr);

  // monitor: pop and compare every emitted vector
  always @(negedge clk) begin
    if (rst_ni && vec_vld) begin
      if (exp_q.size() == 0) begin
        if (!inf_mode) begin
          n_run++; n_fail++;
          $display("FAIL R4 unexpected vector act=%h exp=none", vec);
        end
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        n_run++;
        if (vec !== e) begin
          n_fail++;
          $display("FAIL R4 vector act=%h exp=%h", vec, e);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, expv);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input int addr, input logic [40:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_addr = 6'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [40:0] mk_line(input bit e_end, input bit e_ret, input bit e_call,
      input bit s_en, input int s_sel, input bit s_val, input bit w_en, input int w_ev,
      input int jm, input int j_ev, input bit inf, input int rpt, input int blk, input int tgt);
    return {e_end, e_ret, e_call, s_en, 2'(s_sel), s_val, w_en, 2'(w_ev),
            2'(jm), 2'(j_ev), inf, 16'(rpt), 4'(blk), 6'(tgt)};
  endfunction

  function automatic logic [40:0] blk_w(input int st, input int len);
    return 41'({10'(st), 11'(len)});
  endfunction

  function automatic logic [40:0] ev_w(input bit edg, input bit o, input bit su, input int ss,
      input logic [7:0] m, input logic [7:0] v);
    return 41'({edg, o, su, 2'(ss), m, v});
  endfunction

  // block table mirrored in the bench model
  int bst [6] = '{0, 100, 200, 300, 400, 500};
  int bln [6] = '{5, 6, 4, 3, 6, 8};

  task automatic push_blk(input int b, input int times);
    for (int t = 0; t < times; t++)
      for (int i = 0; i < bln[b]; i++) exp_q.push_back(patf(10'(bst[b] + i)));
  endtask

  task automatic go();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 3000; i++) begin
      if (done || err) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R14 watchdog act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!vec_vld && !pat_rd && !done && !err && ims_out == 4'b0, "R1", "outputs in reset",
        {vec_vld, pat_rd, done, err}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(!vec_vld && !done && !err && ims_out == 4'b0, "R1", "outputs after reset",
        {vec_vld, done, err, ims_out}, 0);

    // R2: descriptors and events
    for (int b = 0; b < 6; b++) wr(2'd1, b, blk_w(bst[b], bln[b]));
    wr(2'd2, 0, ev_w(0, 0, 0, 0, 8'h01, 8'h01));
    wr(2'd2, 1, ev_w(1, 0, 0, 0, 8'h02, 8'h02));
    wr(2'd2, 2, ev_w(0, 1, 1, 1, 8'h0C, 8'h0C));
    wr(2'd2, 3, ev_w(0, 0, 0, 0, 8'h00, 8'h00));

    // A: repeat, unconditional jump, signals, end (R2 R3 R4 R5 R8 R9 R14)
    wr(2'd0, 0, mk_line(0,0,0, 1,2,1, 0,0, 0,0, 0,1, 0,0));
    wr(2'd0, 1, mk_line(0,0,0, 1,0,1, 0,0, 2,0, 0,0, 1,3));
    wr(2'd0, 2, mk_line(0,0,0, 0,0,0, 0,0, 0,0, 0,0, 3,0));
    wr(2'd0, 3, mk_line(1,0,0, 1,2,0, 0,0, 0,0, 0,0, 2,0));
    push_blk(0, 2); push_blk(1, 1); push_blk(2, 1);
    go(); wait_end();
    chk(exp_q.size() == 0, "R5", "stream with repeat and jump, words left", exp_q.size(), 0);
    chk(done && !err, "R14", "done after end line", {done, err}, 2);
    chk(ims_out == 4'b0001, "R9", "signal outputs", ims_out, 1);

    // B: level wait (R6)
    wr(2'd0, 0, mk_line(1,0,0, 0,0,0, 1,0, 0,0, 0,0, 2,0));
    ext = 8'h00; go();
    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0 && !done, "R6", "held by wait", done, 0);
    push_blk(2, 1); ext = 8'h01; wait_end();
    chk(exp_q.size() == 0 && done, "R6", "released by level event", exp_q.size(), 0);

    // C: OR event with cross-module input (R6)
    ext = 8'h00;
    wr(2'd0, 0, mk_line(1,0,0, 0,0,0, 1,2, 0,0, 0,0, 2,0));
    go(); repeat (30) @(negedge clk);
    chk(!done, "R6", "OR event still false", done, 0);
    push_blk(2, 1); ims_in = 4'b0010; wait_end();
    chk(exp_q.size() == 0 && done, "R6", "OR event via cross-module input", exp_q.size(), 0);
    ims_in = 4'b0000;

    // D: edge event (R7)
    ext = 8'h02; repeat (3) @(negedge clk);
    wr(2'd0, 0, mk_line(1,0,0, 0,0,0, 1,1, 0,0, 0,0, 2,0));
    go(); repeat (30) @(negedge clk);
    chk(!done, "R7", "high level gives no edge", done, 0);
    ext = 8'h00; repeat (3) @(negedge clk);
    push_blk(2, 1); ext = 8'h02; wait_end();
    chk(exp_q.size() == 0 && done, "R7", "rising edge releases", exp_q.size(), 0);
    ext = 8'h00;

    // E: conditional jump (R8)
    wr(2'd0, 0, mk_line(0,0,0, 0,0,0, 0,0, 1,0, 0,0, 2,2));
    wr(2'd0, 1, mk_line(1,0,0, 0,0,0, 0,0, 0,0, 0,0, 0,0));
    wr(2'd0, 2, mk_line(1,0,0, 0,0,0, 0,0, 0,0, 0,0, 1,0));
    ext = 8'h01; push_blk(2, 1); push_blk(1, 1);
    go(); wait_end();
    chk(exp_q.size() == 0 && done, "R8", "taken jump", exp_q.size(), 0);
    ext = 8'h00; push_blk(2, 1); push_blk(0, 1);
    go(); wait_end();
    chk(exp_q.size() == 0 && done, "R8", "fall through", exp_q.size(), 0);

    // F: sub-sequence call repeated (R10)
    wr(2'd0, 0,  mk_line(0,0,1, 0,0,0, 0,0, 0,0, 0,2, 0,10));
    wr(2'd0, 1,  mk_line(1,0,0, 0,0,0, 0,0, 0,0, 0,0, 2,0));
    wr(2'd0, 10, mk_line(0,0,0, 0,0,0, 0,0, 0,0, 0,0, 0,0));
    wr(2'd0, 11, mk_line(0,1,0, 0,0,0, 0,0, 0,0, 0,0, 1,0));
    for (int k = 0; k < 3; k++) begin push_blk(0, 1); push_blk(1, 1); end
    push_blk(2, 1);
    go(); wait_end();
    chk(exp_q.size() == 0 && done && !err, "R10", "sub-sequence expansion", exp_q.size(), 0);

    // G: nested call (R11)
    wr(2'd0, 10, mk_line(0,0,1, 0,0,0, 0,0, 0,0, 0,0, 0,20));
    go(); wait_end();
    chk(err && !done, "R11", "nested call flags error", {err, done}, 2);

    // H: minimum length (R12)
    half = 1'b0;
    wr(2'd0, 0, mk_line(1,0,0, 0,0,0, 0,0, 0,0, 0,0, 3,0));
    go(); wait_end();
    chk(err, "R12", "short block full mode", err, 1);
    half = 1'b1;
    wr(2'd0, 0, mk_line(1,0,0, 0,0,0, 0,0, 0,0, 0,0, 4,0));
    go(); wait_end();
    chk(err, "R12", "short block half mode", err, 1);
    wr(2'd0, 0, mk_line(1,0,0, 0,0,0, 0,0, 0,0, 0,0, 5,0));
    push_blk(5, 1);
    go(); wait_end();
    chk(done && !err && exp_q.size() == 0, "R12", "half mode block at minimum", err, 0);
    half = 1'b0;

    // I: step mode (R13)
    step = 1'b1;
    wr(2'd0, 0, mk_line(0,0,0, 0,0,0, 1,3, 1,3, 0,0, 2,2));
    wr(2'd0, 1, mk_line(1,0,0, 0,0,0, 0,0, 0,0, 0,0, 0,0));
    wr(2'd0, 2, mk_line(1,0,0, 0,0,0, 0,0, 0,0, 0,0, 1,0));
    go(); repeat (20) @(negedge clk);
    chk(!done, "R13", "true event ignored in step mode", done, 0);
    push_blk(2, 1); push_blk(0, 1);
    pulse_ack(); wait_end();
    chk(exp_q.size() == 0 && done, "R13", "no ack during block, no jump", exp_q.size(), 0);
    push_blk(2, 1); push_blk(1, 1);
    go(); repeat (10) @(negedge clk);
    pulse_ack(); pulse_ack(); wait_end();
    chk(exp_q.size() == 0 && done, "R13", "ack during block takes jump", exp_q.size(), 0);
    step = 1'b0;

    // J: infinite repeat (R5)
    wr(2'd0, 0, mk_line(1,0,0, 0,0,0, 0,0, 2,0, 1,0, 2,1));
    push_blk(2, 5); inf_mode = 1'b1;
    go();
    for (int i = 0; i < 400; i++) begin
      if (exp_q.size() == 0) break;
      @(negedge clk);
    end
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0 && !done && !err && vec_vld, "R5", "infinite repeat keeps running",
        {done, err, vec_vld}, 1);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    inf_mode = 1'b0; rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(!vec_vld && !done && ims_out == 4'b0, "R1", "reset stops run", vec_vld, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule